// File: doc/BRIEF.md
# Dual-Channel Serial Frame Sync Controller

This block decides when a master serial port issues a frame sync for two data channels, A and B. Both channels share one serial bit clock and one frame-sync line, so one decision governs both. The bit clock arrives as a one-cycle enable tick, and all timing is counted in those ticks. A 16-bit period value is taken from the upper half of a 32-bit divisor word. A down-counter reloads from that value each time a sync is issued.

Two policies are available. In data-dependent mode, a sync at counter expiry is held back until the buffer state of both channels allows it. When transmitting, both transmit buffers must hold a word. When receiving, neither receive buffer may be full. In free-running mode, syncs are issued at the divisor rate whatever the buffers hold. A channel that was not ready when such a sync fired raises a sticky error flag: underrun when transmitting, overflow when receiving.

Each issued sync also toggles a left/right slot indicator and sends one load/store strobe to each channel. The strobe goes to a DMA request or to a core request, chosen by that channel's own DMA-enable input. Clearing the master enable returns the block to its idle state.

Top module: `fsync_dual_ctrl`

## Requirements
- R1: The sync period value P is bits 31:16 of `div_reg`. Bits 15:0 have no effect. After enable, with the sync condition always true, syncs are issued on bit-clock ticks P+1, 2(P+1), and so on.
- R2: With `dir_tx`=1 (transmit) and `free_run`=0, a sync is issued only on a tick where both `tx_rdy_a` and `tx_rdy_b` are 1. In this direction the `rx_full_*` inputs have no effect.
- R3: With `dir_tx`=0 (receive) and `free_run`=0, a sync is issued only on a tick where both `rx_full_a` and `rx_full_b` are 0. In this direction the `tx_rdy_*` inputs have no effect.
- R4: When a sync is held back at expiry, the counter stays at zero. The sync is issued on the first tick on which the buffer condition is true.
- R5: With `free_run`=1, syncs are issued at the R1 rate whatever the buffer inputs are.
- R6: `fs_out` is active high. It rises on the clock edge of the issuing tick and falls on the clock edge of the next tick, unless that tick also issues a sync.
- R7: While `master_en`=0, `chan_left` equals the inverse of `left_first`. Each sync toggles it. The first sync after enable therefore selects left (1) when `left_first`=1 and right (0) when `left_first`=0.
- R8: Each sync produces a one-clock strobe per channel, in the clock cycle after the issuing tick. The strobe appears on `xfer_dma_x` when `dma_en_x`=1 and on `xfer_core_x` otherwise, and the two channels choose independently.
- R9: In free-running mode, a sync sets `err_x` if channel x was not ready. When transmitting, not ready means `tx_rdy_x`=0. When receiving, it means `rx_full_x`=1. The flag stays set until disable. Data-dependent syncs never set it.
- R10: While `master_en`=0, no sync is issued and no strobe appears. The clock edge after `master_en` falls clears `fs_out` and both error flags and reloads the counter.
- R11: While `rst_n` is low, `fs_out`, all strobes and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_tick | input | 1 | One-cycle enable per serial bit clock |
| master_en | input | 1 | Master enable. 0 holds the block idle |
| dir_tx | input | 1 | 1 = transmit, 0 = receive |
| free_run | input | 1 | 1 = free-running syncs, 0 = data-dependent syncs |
| left_first | input | 1 | 1 = left slot first, 0 = right slot first |
| div_reg | input | 32 | Divisor word. Bits 31:16 hold the sync period |
| dma_en_a | input | 1 | Channel A strobe goes to DMA |
| dma_en_b | input | 1 | Channel B strobe goes to DMA |
| tx_rdy_a | input | 1 | Channel A transmit buffer holds a word |
| tx_rdy_b | input | 1 | Channel B transmit buffer holds a word |
| rx_full_a | input | 1 | Channel A receive buffer is full |
| rx_full_b | input | 1 | Channel B receive buffer is full |
| fs_out | output | 1 | Frame-sync pulse, one bit clock wide |
| chan_left | output | 1 | Current slot: 1 = left, 0 = right |
| xfer_dma_a | output | 1 | Channel A DMA strobe |
| xfer_core_a | output | 1 | Channel A core strobe |
| xfer_dma_b | output | 1 | Channel B DMA strobe |
| xfer_core_b | output | 1 | Channel B core strobe |
| err_a | output | 1 | Channel A underrun or overflow, sticky |
| err_b | output | 1 | Channel B underrun or overflow, sticky |

## Verification
The bench uses the default parameters: a 32-bit divisor word with the period field at bits 31:16, and two channels. The period values it applies are small (0 to 11), so a 12-tick window shows several sync periods, including back-to-back syncs at period 0. Junk in the divisor's lower half shows that those bits are ignored. Since both channels are built, the bench can pit one ready channel against one blocked channel, and can use mixed DMA routing.

// File: rtl/fsync_pkg.sv
// Package: shared sizes and the buffer-readiness rule for the frame-sync
// controller. Assumes exactly two channels share one sync line.
package fsync_pkg;
    localparam int DIV_W  = 32;
    localparam int FS_LSB = 16;
    localparam int FS_W   = 16;
    localparam int NUM_CH = 2;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dir_e;

    // A channel is ready when it can take part in the next frame.
    function automatic logic lane_ready(input dir_e dir, input logic rdy, input logic full);
        return (dir == DIR_TX) ? rdy : !full;
    endfunction
endpackage

// File: rtl/fsync_period_cnt.sv
// Module: sync period down-counter.
// Counts bit-clock ticks from the reload value to zero. At zero it waits
// for a fire request, then reloads. Assumes fire is only raised on a tick
// while at zero.
module fsync_period_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic          fire,
    input  logic [CW-1:0] reload,
    output logic          at_zero
);
    logic [CW-1:0] cnt_q;

    // Count down on ticks, hold at zero until fired, reload on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= reload;
        end else if (tick) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (fire) begin
                cnt_q <= reload;
            end
        end
    end

    assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/fsync_gate.sv
// Module: sync decision logic (combinational).
// Decides whether a sync issues this cycle, and which lanes are not ready.
// Assumes the per-lane inputs are already stable in the tick's cycle.
module fsync_gate
    import fsync_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic           en,
    input  logic           tick,
    input  logic           at_zero,
    input  logic           dir_tx,
    input  logic           free_run,
    input  logic [NCH-1:0] rdy,
    input  logic [NCH-1:0] full,
    output logic [NCH-1:0] miss,
    output logic           issue
);
    logic [NCH-1:0] ok;
    dir_e           dir;

    assign dir = dir_tx ? DIR_TX : DIR_RX;

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        assign ok[i]   = lane_ready(dir, rdy[i], full[i]);
        assign miss[i] = !ok[i];
    end

    // Issue at expiry when free-running or when every lane is ready.
    always_comb begin
        issue = en && tick && at_zero && (free_run || (&ok));
    end
endmodule

// File: rtl/fsync_lane.sv
// Module: per-channel strobe routing and sticky error flag.
// Gives one strobe per issued sync, routed by the DMA enable. Latches an
// error when a free-running sync finds the lane not ready.
module fsync_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic issue,
    input  logic free_run,
    input  logic miss,
    input  logic dma_en,
    output logic xfer_dma,
    output logic xfer_core,
    output logic err
);
    // Register one-cycle strobes on the chosen path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_dma  <= 1'b0;
            xfer_core <= 1'b0;
        end else begin
            xfer_dma  <= issue && dma_en;
            xfer_core <= issue && !dma_en;
        end
    end

    // Sticky underrun/overflow flag, cleared on disable.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            err <= 1'b0;
        end else if (issue && free_run && miss) begin
            err <= 1'b1;
        end
    end
endmodule

// File: rtl/fsync_frame_out.sv
// Module: frame-sync pulse and slot indicator.
// The pulse lasts one bit clock. The slot bit toggles on each sync and
// rests at the inverse of the first slot while disabled.
module fsync_frame_out (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic issue,
    input  logic left_first,
    output logic fs_out,
    output logic chan_left
);
    // Pulse level is refreshed on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fs_out <= 1'b0;
        end else if (tick) begin
            fs_out <= issue;
        end
    end

    // Slot indicator: preset while disabled, toggle per sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_left <= 1'b0;
        end else if (clr) begin
            chan_left <= !left_first;
        end else if (issue) begin
            chan_left <= !chan_left;
        end
    end
endmodule

// File: rtl/fsync_dual_ctrl.sv
// Module: top of the dual-channel frame-sync controller.
// Takes the period field from the divisor word, decides on syncs and
// drives the pulse, the slot bit and the per-channel strobes.
// Assumes bclk_tick is a single-cycle enable.
module fsync_dual_ctrl
    import fsync_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_tick,
    input  logic             master_en,
    input  logic             dir_tx,
    input  logic             free_run,
    input  logic             left_first,
    input  logic [DIV_W-1:0] div_reg,
    input  logic             dma_en_a,
    input  logic             dma_en_b,
    input  logic             tx_rdy_a,
    input  logic             tx_rdy_b,
    input  logic             rx_full_a,
    input  logic             rx_full_b,
    output logic             fs_out,
    output logic             chan_left,
    output logic             xfer_dma_a,
    output logic             xfer_core_a,
    output logic             xfer_dma_b,
    output logic             xfer_core_b,
    output logic             err_a,
    output logic             err_b
);
    localparam int FS_MSB = FS_LSB + FS_W - 1;

    logic [FS_W-1:0]   period;
    logic              unused_low;
    logic              clr;
    logic              at_zero;
    logic              issue;
    logic [NUM_CH-1:0] rdy_v, full_v, dma_v, miss_v;
    logic [NUM_CH-1:0] xd_v, xc_v, err_v;

    assign period     = div_reg[FS_MSB:FS_LSB];
    assign unused_low = ^div_reg[FS_LSB-1:0];
    assign clr        = !master_en;

    assign rdy_v  = {tx_rdy_b, tx_rdy_a};
    assign full_v = {rx_full_b, rx_full_a};
    assign dma_v  = {dma_en_b, dma_en_a};

    fsync_period_cnt #(.CW(FS_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(bclk_tick),
        .fire(issue), .reload(period), .at_zero(at_zero)
    );

    fsync_gate #(.NCH(NUM_CH)) u_gate (
        .en(master_en), .tick(bclk_tick), .at_zero(at_zero),
        .dir_tx(dir_tx), .free_run(free_run), .rdy(rdy_v),
        .full(full_v), .miss(miss_v), .issue(issue)
    );

    fsync_frame_out u_out (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(bclk_tick),
        .issue(issue), .left_first(left_first),
        .fs_out(fs_out), .chan_left(chan_left)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        fsync_lane u_lane (
            .clk(clk), .rst_n(rst_n), .clr(clr), .issue(issue),
            .free_run(free_run), .miss(miss_v[i]), .dma_en(dma_v[i]),
            .xfer_dma(xd_v[i]), .xfer_core(xc_v[i]), .err(err_v[i])
        );
    end

    assign xfer_dma_a  = xd_v[0];
    assign xfer_core_a = xc_v[0];
    assign xfer_dma_b  = xd_v[1];
    assign xfer_core_b = xc_v[1];
    assign err_a       = err_v[0];
    assign err_b       = err_v[1];
endmodule

// File: rtl/fsync_dual_ctrl_chk.sv
// Module: property checker for fsync_dual_ctrl, attached by bind.
// Watches the ports only.
module fsync_dual_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic bclk_tick,
    input logic master_en,
    input logic dir_tx,
    input logic free_run,
    input logic dma_en_a,
    input logic tx_rdy_a,
    input logic tx_rdy_b,
    input logic rx_full_a,
    input logic rx_full_b,
    input logic fs_out,
    input logic xfer_dma_a,
    input logic xfer_core_a,
    input logic err_a,
    input logic err_b
);
    logic str_a;
    assign str_a = xfer_dma_a || xfer_core_a;

    assert_tx_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (str_a && $past(master_en && dir_tx && !free_run)) |-> $past(tx_rdy_a && tx_rdy_b));

    assert_rx_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (str_a && $past(master_en && !dir_tx && !free_run)) |-> $past(!rx_full_a && !rx_full_b));

    assert_fs_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_out) |-> $past(bclk_tick));

    assert_route_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xfer_dma_a, xfer_core_a}));

    assert_route_dma_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_dma_a |-> $past(dma_en_a));

    assert_err_free_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_a) |-> $past(free_run && master_en));

    assert_idle_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> (!fs_out && !err_a && !err_b));

    assert_idle_nostrobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !str_a);
endmodule

bind fsync_dual_ctrl fsync_dual_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick), .master_en(master_en),
    .dir_tx(dir_tx), .free_run(free_run), .dma_en_a(dma_en_a),
    .tx_rdy_a(tx_rdy_a), .tx_rdy_b(tx_rdy_b), .rx_full_a(rx_full_a),
    .rx_full_b(rx_full_b), .fs_out(fs_out), .xfer_dma_a(xfer_dma_a),
    .xfer_core_a(xfer_core_a), .err_a(err_a), .err_b(err_b)
);

// File: tb/fsync_dual_ctrl_test.sv
module fsync_dual_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk_tick = 1'b0, master_en = 1'b0, dir_tx = 1'b0, free_run = 1'b0;
    logic left_first = 1'b0, dma_en_a = 1'b0, dma_en_b = 1'b0;
    logic tx_rdy_a = 1'b0, tx_rdy_b = 1'b0, rx_full_a = 1'b0, rx_full_b = 1'b0;
    logic [31:0] div_reg = '0;
    logic fs_out, chan_left, xfer_dma_a, xfer_core_a, xfer_dma_b, xfer_core_b, err_a, err_b;

    int n_checks = 0, n_fail = 0;
    int c_da = 0, c_ca = 0, c_db = 0, c_cb = 0;

    always #2.5 clk = !clk;

    fsync_dual_ctrl uut (.*);

    // Strobe counters sampled away from the active edge.
    always @(negedge clk) begin
        if (xfer_dma_a)  c_da++;
        if (xfer_core_a) c_ca++;
        if (xfer_dma_b)  c_db++;
        if (xfer_core_b) c_cb++;
    end

    typedef struct packed {
        logic       tx, fr, ra, rb, fa, fb, lf, da, db;
        logic [15:0] per;
        logic [7:0]  syncs;
        logic       ea, eb;
    } vec_t;

    localparam int NV = 8;
    localparam int WIN = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,16'd2, 8'd4, 1'b0,1'b0},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'd1, 8'd0, 1'b0,1'b0},
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,16'd3, 8'd3, 1'b1,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'd0, 8'd12,1'b0,1'b0},
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,16'd0, 8'd0, 1'b0,1'b0},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,16'd5, 8'd2, 1'b0,1'b1},
        '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,16'd11,8'd1, 1'b0,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,16'd4, 8'd2, 1'b0,1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) bclk_tick = 1'b1;
            @(negedge clk) bclk_tick = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int s_da, s_ca, s_db, s_cb, sa, sb, ok_l;
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11 fs_out", fs_out, 0);
        chk("R11 err", {err_a, err_b}, 0);
        chk("R11 strobes", {xfer_dma_a, xfer_core_a, xfer_dma_b, xfer_core_b}, 0);
        rst_n = 1'b1;

        // Vector table: R1 R2 R3 R5 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            @(negedge clk) master_en = 1'b0;
            dir_tx = VECS[v].tx; free_run = VECS[v].fr;
            tx_rdy_a = VECS[v].ra; tx_rdy_b = VECS[v].rb;
            rx_full_a = VECS[v].fa; rx_full_b = VECS[v].fb;
            left_first = VECS[v].lf; dma_en_a = VECS[v].da; dma_en_b = VECS[v].db;
            div_reg = {VECS[v].per, 16'hA5C3 ^ 16'(v * 16'h1111)};
            repeat (2) @(negedge clk);
            master_en = 1'b1;
            s_da = c_da; s_ca = c_ca; s_db = c_db; s_cb = c_cb;
            run_ticks(WIN);
            sa = (c_da - s_da) + (c_ca - s_ca);
            sb = (c_db - s_db) + (c_cb - s_cb);
            // R1/R2/R3/R5: sync count over the window
            chk($sformatf("R1 R2 R3 R5 syncs vec%0d", v), sa, int'(VECS[v].syncs));
            chk($sformatf("R8 lane b syncs vec%0d", v), sb, int'(VECS[v].syncs));
            chk($sformatf("R8 dma route a vec%0d", v), c_da - s_da, VECS[v].da ? int'(VECS[v].syncs) : 0);
            chk($sformatf("R8 dma route b vec%0d", v), c_db - s_db, VECS[v].db ? int'(VECS[v].syncs) : 0);
            ok_l = (VECS[v].syncs % 2 == 1) ? int'(VECS[v].lf) : int'(!VECS[v].lf);
            chk($sformatf("R7 slot vec%0d", v), chan_left, ok_l);
            chk($sformatf("R9 err a vec%0d", v), err_a, int'(VECS[v].ea));
            chk($sformatf("R9 err b vec%0d", v), err_b, int'(VECS[v].eb));
        end

        // R4 and R6: withheld sync fires on first ready tick, pulse width
        @(negedge clk) master_en = 1'b0;
        dir_tx = 1'b1; free_run = 1'b0; tx_rdy_a = 1'b1; tx_rdy_b = 1'b0;
        left_first = 1'b1; dma_en_a = 1'b0; dma_en_b = 1'b0;
        div_reg = {16'd2, 16'hFFFF};
        repeat (2) @(negedge clk);
        chk("R7 idle slot", chan_left, 0);
        master_en = 1'b1;
        s_ca = c_ca;
        run_ticks(8);
        chk("R4 held", c_ca - s_ca, 0);
        chk("R4 fs low while held", fs_out, 0);
        tx_rdy_b = 1'b1;
        @(negedge clk) bclk_tick = 1'b1;
        @(negedge clk) bclk_tick = 1'b0;
        chk("R4 fires first ready tick", fs_out, 1);
        chk("R4 strobe", xfer_core_a, 1);
        chk("R7 first slot left", chan_left, 1);
        @(negedge clk);
        chk("R8 strobe one cycle", xfer_core_a, 0);
        chk("R6 fs held between ticks", fs_out, 1);
        @(negedge clk) bclk_tick = 1'b1;
        @(negedge clk) bclk_tick = 1'b0;
        chk("R6 fs falls next tick", fs_out, 0);

        // R9 sticky, then R10 clear on disable
        free_run = 1'b1; tx_rdy_a = 1'b0;
        div_reg = {16'd0, 16'h0000};
        run_ticks(3);
        chk("R9 underrun set", err_a, 1);
        tx_rdy_a = 1'b1;
        run_ticks(2);
        chk("R9 sticky", err_a, 1);
        chk("R9 ready lane clean", err_b, 0);
        @(negedge clk) master_en = 1'b0;
        @(negedge clk);
        chk("R10 err cleared", err_a, 0);
        chk("R10 fs cleared", fs_out, 0);
        chk("R7 idle slot inverse", chan_left, 0);
        s_ca = c_ca;
        run_ticks(4);
        chk("R10 no strobe idle", c_ca - s_ca, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule